// File: doc/BRIEF.md
# Segmented Address Router with Page Protection

This block sits between an execution unit and three targets: on-chip RAM, an external memory bus and an I/O port bus. For each access it takes a segment base and an offset. It adds them into a signed effective address and picks the target from the sign and the magnitude of that address. It also checks the access against the attributes of the 128-byte page it falls in. Exactly one request strobe or one numbered fault comes out one cycle after the access is presented.

Page attributes sit in a small register file. Each page has a read, a write and an execute permission bit plus a run-level value. An update port changes one attribute of one page per cycle. The caller supplies the run level of the page it is currently executing from. A caller whose run level does not exceed the target page's run level may read and write that page whatever its read and write bits say. Instruction fetch always needs the execute bit.

Top module: `seg_addr_router`

## Requirements
- R1: The effective address is seg_base + offset in 24-bit two's complement. If that sum overflows the signed range, the access raises fault code 15.
- R2: A negative effective address selects the port bus with port number -EA-1, so address -1 is port 0. A port number of 1024 or above raises fault 10.
- R3: With on-chip RAM enabled, a non-negative address below 65536 raises ram_req with ram_addr equal to the address.
- R4: With on-chip RAM enabled, an address at or above 65536 raises mem_req with mem_addr = EA-65536. An external offset of 65536 or more raises fault 8.
- R5: With on-chip RAM disabled, every non-negative address goes to the memory bus unchanged, so address 0 is bus offset 0, with the same 65536-byte range check.
- R6: After reset every page is readable, writable and executable with run level 0. The update port selects the attribute with attr_sel: 0 read, 1 write, 2 execute, 3 run level (taken from attr_rl). An update takes effect from the next cycle, so an access in the update cycle sees the old attributes. Only addresses below 64×128 are checked.
- R7: A read to a page whose read bit is clear raises fault 12 when cur_rl is greater than the page run level. Otherwise the read goes ahead.
- R8: A write to a page whose write bit is clear raises fault 9 when cur_rl is greater than the page run level. Otherwise the write goes ahead.
- R9: A fetch from a page whose execute bit is clear raises fault 14 at any run level. A fetch from a negative address raises fault 15.
- R10: Outputs are registered. The cycle after acc_valid shows exactly one of ram_req, mem_req, io_req or fault_vld, each for one cycle. A fault suppresses every request. With no access, all strobes are low and fault_code is 0.
- R11: When several faults apply, 15 takes priority over 10 and 8, and those take priority over the permission faults.
- R12: acc_type encodes 0 read, 1 write, 2 fetch; code 3 behaves as a read. bus_we is high, and bus_wdata equals wdata, only with a granted write. Otherwise bus_wdata is 0.
- R13: While rst_n is low, all strobes, bus_we, bus_wdata and fault_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| seg_base | input | 24 | Segment base value |
| offset | input | 24 | Offset from the instruction |
| cur_rl | input | 2 | Run level of the executing page |
| wdata | input | 32 | Write data |
| attr_we | input | 1 | Attribute update strobe |
| attr_page | input | 6 | Page to update |
| attr_sel | input | 2 | Attribute selector |
| attr_bit | input | 1 | New permission bit value |
| attr_rl | input | 2 | New run level (selector 3) |
| ram_req | output | 1 | On-chip RAM request |
| ram_addr | output | 16 | On-chip RAM byte address |
| mem_req | output | 1 | External memory bus request |
| mem_addr | output | 23 | External memory bus offset |
| io_req | output | 1 | Port bus request |
| io_port | output | 10 | Port number |
| bus_we | output | 1 | Granted request is a write |
| bus_wdata | output | 32 | Write data of a granted write |
| fault_vld | output | 1 | Fault strobe |
| fault_code | output | 4 | Fault number, 0 when none |

## Verification
The checker assumes that acc_type and the attribute inputs are stable and known at each rising edge. It also assumes that reset is asserted from time zero, so every past-value property starts from cleared registers. The stimulus changes inputs only on falling edges and keeps rst_n low for the first cycles. It draws addresses from segment bases near zero, near the RAM top, near the positive limit and in the negative range, so the overflow, port-range and bus-range edges all occur. A second instance with on-chip RAM disabled receives the same stimulus.

// File: rtl/seg_router_pkg.sv
package seg_router_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [3:0] {
      FLT_NONE   = 4'd0,
      FLT_MEMBUS = 4'd8,
      FLT_WRITE  = 4'd9,
      FLT_PORT   = 4'd10,
      FLT_READ   = 4'd12,
      FLT_EXEC   = 4'd14,
      FLT_SPACE  = 4'd15
   } fault_e;

   typedef enum logic [1:0] {
      SEL_RD = 2'd0,
      SEL_WR = 2'd1,
      SEL_EX = 2'd2,
      SEL_RL = 2'd3
   } attr_sel_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RAM  = 2'd1,
      DST_MEM  = 2'd2,
      DST_IO   = 2'd3
   } dest_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } perm_t;

endpackage

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
   parameter int ADDR_W     = 24,
   parameter bit INT_RAM_EN = 1'b1,
   parameter int RAM_BYTES  = 65536,
   parameter int EXT_BYTES  = 65536,
   parameter int IO_PORTS   = 1024,
   parameter int PROT_BYTES = 8192,
   parameter int PAGE_SH    = 7,
   parameter int PG_W       = 6,
   parameter int RAM_AW     = 16,
   parameter int PORT_W     = 10
) (
   input  logic [ADDR_W-1:0] seg_base,
   input  logic [ADDR_W-1:0] offset,
   output logic              ovf,
   output logic              neg,
   output logic              in_ram,
   output logic              ext_ok,
   output logic              port_ok,
   output logic              in_prot,
   output logic [PG_W-1:0]   page_idx,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [ADDR_W-2:0] ext_addr,
   output logic [PORT_W-1:0] port
);
   localparam int MSB = ADDR_W - 1;
   localparam logic [ADDR_W-1:0] RAM_LIM  = ADDR_W'(RAM_BYTES);
   localparam logic [ADDR_W-1:0] EXT_LIM  = ADDR_W'(EXT_BYTES);
   localparam logic [ADDR_W-1:0] PORT_LIM = ADDR_W'(IO_PORTS);
   localparam logic [ADDR_W-1:0] PROT_LIM = ADDR_W'(PROT_BYTES);

   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] ext_full;
   logic [ADDR_W-1:0] port_full;

   assign sum       = seg_base + offset;
   assign ovf       = (seg_base[MSB] == offset[MSB]) && (sum[MSB] != seg_base[MSB]);
   assign neg       = sum[MSB];
   assign port_full = ~sum;
   assign port_ok   = port_full < PORT_LIM;
   assign in_prot   = !sum[MSB] && (sum < PROT_LIM);
   assign page_idx  = sum[PAGE_SH+PG_W-1:PAGE_SH];
   assign ram_addr  = sum[RAM_AW-1:0];
   assign port      = port_full[PORT_W-1:0];

   generate
      if (INT_RAM_EN) begin : g_ram
         assign in_ram   = !sum[MSB] && (sum < RAM_LIM);
         assign ext_full = sum - RAM_LIM;
      end else begin : g_noram
         assign in_ram   = 1'b0;
         assign ext_full = sum;
      end
   endgenerate

   assign ext_ok   = !sum[MSB] && (ext_full < EXT_LIM);
   assign ext_addr = ext_full[ADDR_W-2:0];

endmodule

// File: rtl/page_attr_file.sv
module page_attr_file
   import seg_router_pkg::*;
#(
   parameter int NUM_PAGES = 64,
   parameter int RL_W      = 2,
   parameter int PG_W      = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en,
   input  logic [PG_W-1:0] upd_page,
   input  attr_sel_e       upd_sel,
   input  logic            upd_bit,
   input  logic [RL_W-1:0] upd_rl,
   input  logic [PG_W-1:0] rd_page,
   output perm_t           rd_perm,
   output logic [RL_W-1:0] rd_rl
);
   perm_t           perm_q [NUM_PAGES];
   logic [RL_W-1:0] rl_q   [NUM_PAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PAGES; i++) begin
            perm_q[i] <= '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            rl_q[i]   <= '0;
         end
      end else if (upd_en) begin
         case (upd_sel)
            SEL_RD:  perm_q[upd_page].rd <= upd_bit;
            SEL_WR:  perm_q[upd_page].wr <= upd_bit;
            SEL_EX:  perm_q[upd_page].ex <= upd_bit;
            default: rl_q[upd_page]      <= upd_rl;
         endcase
      end
   end

   assign rd_perm = perm_q[rd_page];
   assign rd_rl   = rl_q[rd_page];

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
   import seg_router_pkg::*;
#(
   parameter int RL_W = 2
) (
   input  acc_e            acc,
   input  logic            in_prot,
   input  perm_t           perm,
   input  logic [RL_W-1:0] page_rl,
   input  logic [RL_W-1:0] cur_rl,
   output logic            deny,
   output fault_e          code
);
   logic rl_bypass;
   assign rl_bypass = cur_rl <= page_rl;

   always_comb begin
      deny = 1'b0;
      code = FLT_NONE;
      if (in_prot) begin
         case (acc)
            ACC_FETCH: if (!perm.ex) begin
               deny = 1'b1;
               code = FLT_EXEC;
            end
            ACC_WRITE: if (!perm.wr && !rl_bypass) begin
               deny = 1'b1;
               code = FLT_WRITE;
            end
            default: if (!perm.rd && !rl_bypass) begin
               deny = 1'b1;
               code = FLT_READ;
            end
         endcase
      end
   end

endmodule

// File: rtl/seg_addr_router.sv
module seg_addr_router
   import seg_router_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 32,
   parameter int PAGE_BYTES = 128,
   parameter int NUM_PAGES  = 64,
   parameter int RL_W       = 2,
   parameter bit INT_RAM_EN = 1'b1,
   parameter int RAM_BYTES  = 65536,
   parameter int EXT_BYTES  = 65536,
   parameter int IO_PORTS   = 1024
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           acc_valid,
   input  logic [1:0]                     acc_type,
   input  logic [ADDR_W-1:0]              seg_base,
   input  logic [ADDR_W-1:0]              offset,
   input  logic [RL_W-1:0]                cur_rl,
   input  logic [DATA_W-1:0]              wdata,
   input  logic                           attr_we,
   input  logic [$clog2(NUM_PAGES)-1:0]   attr_page,
   input  logic [1:0]                     attr_sel,
   input  logic                           attr_bit,
   input  logic [RL_W-1:0]                attr_rl,
   output logic                           ram_req,
   output logic [$clog2(RAM_BYTES)-1:0]   ram_addr,
   output logic                           mem_req,
   output logic [ADDR_W-2:0]              mem_addr,
   output logic                           io_req,
   output logic [$clog2(IO_PORTS)-1:0]    io_port,
   output logic                           bus_we,
   output logic [DATA_W-1:0]              bus_wdata,
   output logic                           fault_vld,
   output logic [3:0]                     fault_code
);
   localparam int PAGE_SH    = $clog2(PAGE_BYTES);
   localparam int PG_W       = $clog2(NUM_PAGES);
   localparam int PORT_W     = $clog2(IO_PORTS);
   localparam int RAM_AW     = $clog2(RAM_BYTES);
   localparam int PROT_BYTES = NUM_PAGES * PAGE_BYTES;

   if ((1 << PAGE_SH) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << PG_W) != NUM_PAGES) begin : g_bad_npages
      $error("NUM_PAGES must be a power of two");
   end
   if ((1 << RAM_AW) != RAM_BYTES) begin : g_bad_ram
      $error("RAM_BYTES must be a power of two");
   end
   if (PAGE_SH + PG_W > ADDR_W - 1) begin : g_bad_prot
      $error("protected span exceeds the positive address range");
   end
   if (longint'(RAM_BYTES) + longint'(EXT_BYTES) > (longint'(1) << (ADDR_W - 1))) begin : g_bad_span
      $error("RAM plus external span exceeds the positive address range");
   end

   acc_e              acc;
   logic              ea_ovf, ea_neg, in_ram, ext_ok, port_ok, in_prot;
   logic [PG_W-1:0]   page_idx;
   logic [RAM_AW-1:0] ram_addr_c;
   logic [ADDR_W-2:0] ext_addr_c;
   logic [PORT_W-1:0] port_c;
   perm_t             pg_perm;
   logic [RL_W-1:0]   pg_rl;
   logic              perm_deny;
   fault_e            perm_code;
   fault_e            flt_c;
   dest_e             dst_c;

   assign acc = acc_e'(acc_type);

   seg_addr_calc #(
      .ADDR_W(ADDR_W), .INT_RAM_EN(INT_RAM_EN), .RAM_BYTES(RAM_BYTES),
      .EXT_BYTES(EXT_BYTES), .IO_PORTS(IO_PORTS), .PROT_BYTES(PROT_BYTES),
      .PAGE_SH(PAGE_SH), .PG_W(PG_W), .RAM_AW(RAM_AW), .PORT_W(PORT_W)
   ) u_calc (
      .seg_base (seg_base),
      .offset   (offset),
      .ovf      (ea_ovf),
      .neg      (ea_neg),
      .in_ram   (in_ram),
      .ext_ok   (ext_ok),
      .port_ok  (port_ok),
      .in_prot  (in_prot),
      .page_idx (page_idx),
      .ram_addr (ram_addr_c),
      .ext_addr (ext_addr_c),
      .port     (port_c)
   );

   page_attr_file #(.NUM_PAGES(NUM_PAGES), .RL_W(RL_W), .PG_W(PG_W)) u_attr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (attr_we),
      .upd_page (attr_page),
      .upd_sel  (attr_sel_e'(attr_sel)),
      .upd_bit  (attr_bit),
      .upd_rl   (attr_rl),
      .rd_page  (page_idx),
      .rd_perm  (pg_perm),
      .rd_rl    (pg_rl)
   );

   page_perm_check #(.RL_W(RL_W)) u_perm (
      .acc     (acc),
      .in_prot (in_prot),
      .perm    (pg_perm),
      .page_rl (pg_rl),
      .cur_rl  (cur_rl),
      .deny    (perm_deny),
      .code    (perm_code)
   );

   // fault priority: address space, then bus range, then page permission
   always_comb begin
      flt_c = FLT_NONE;
      dst_c = DST_NONE;
      if (ea_ovf || (acc == ACC_FETCH && ea_neg)) begin
         flt_c = FLT_SPACE;
      end else if (ea_neg) begin
         if (port_ok) dst_c = DST_IO;
         else         flt_c = FLT_PORT;
      end else if (in_ram) begin
         dst_c = DST_RAM;
      end else if (ext_ok) begin
         dst_c = DST_MEM;
      end else begin
         flt_c = FLT_MEMBUS;
      end
      if (dst_c != DST_NONE && perm_deny) begin
         flt_c = perm_code;
         dst_c = DST_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_req    <= 1'b0;
         mem_req    <= 1'b0;
         io_req     <= 1'b0;
         bus_we     <= 1'b0;
         bus_wdata  <= '0;
         fault_vld  <= 1'b0;
         fault_code <= FLT_NONE;
         ram_addr   <= '0;
         mem_addr   <= '0;
         io_port    <= '0;
      end else begin
         ram_req    <= acc_valid && dst_c == DST_RAM;
         mem_req    <= acc_valid && dst_c == DST_MEM;
         io_req     <= acc_valid && dst_c == DST_IO;
         bus_we     <= acc_valid && dst_c != DST_NONE && acc == ACC_WRITE;
         bus_wdata  <= (acc_valid && dst_c != DST_NONE && acc == ACC_WRITE) ? wdata : '0;
         fault_vld  <= acc_valid && flt_c != FLT_NONE;
         fault_code <= acc_valid ? flt_c : FLT_NONE;
         ram_addr   <= ram_addr_c;
         mem_addr   <= ext_addr_c;
         io_port    <= port_c;
      end
   end

endmodule

// File: rtl/seg_addr_router_chk.sv
module seg_addr_router_chk
   import seg_router_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_type,
   input logic [ADDR_W-1:0] seg_base,
   input logic [ADDR_W-1:0] offset,
   input logic              ram_req,
   input logic              mem_req,
   input logic              io_req,
   input logic              bus_we,
   input logic              fault_vld,
   input logic [3:0]        fault_code
);
   logic [ADDR_W-1:0] sum_c;
   assign sum_c = seg_base + offset;

   // R10
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req, mem_req, io_req, fault_vld}));

   // R10
   strobe_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req || mem_req || io_req || fault_vld) |-> $past(acc_valid));

   // R10
   idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_vld |-> fault_code == 4'd0);

   // R12
   we_only_granted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> ($past(acc_type) == 2'(ACC_WRITE)) && (ram_req || mem_req || io_req));

   // R2
   io_from_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> $past(sum_c[ADDR_W-1]));

   // R9
   no_fetch_on_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> $past(acc_type) != 2'(ACC_FETCH));

   // R8
   write_fault_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && fault_code == 4'(FLT_WRITE)) |-> $past(acc_type) == 2'(ACC_WRITE));

   // R9
   exec_fault_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && fault_code == 4'(FLT_EXEC)) |-> $past(acc_type) == 2'(ACC_FETCH));

   // R7
   read_fault_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && fault_code == 4'(FLT_READ)) |->
         ($past(acc_type) == 2'(ACC_READ) || $past(acc_type) == 2'(ACC_RSVD)));

   // R11
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld |-> (fault_code inside {4'd8, 4'd9, 4'd10, 4'd12, 4'd14, 4'd15}));

endmodule

bind seg_addr_router seg_addr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_type   (acc_type),
   .seg_base   (seg_base),
   .offset     (offset),
   .ram_req    (ram_req),
   .mem_req    (mem_req),
   .io_req     (io_req),
   .bus_we     (bus_we),
   .fault_vld  (fault_vld),
   .fault_code (fault_code)
);

// File: tb/seg_addr_router_tb.sv
`timescale 1ns/1ps
module seg_addr_router_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        acc_valid = 1'b0;
   logic [1:0]  acc_type = '0;
   logic [23:0] seg_base = '0, offset = '0;
   logic [1:0]  cur_rl = '0;
   logic [31:0] wdata = '0;
   logic        attr_we = 1'b0;
   logic [5:0]  attr_page = '0;
   logic [1:0]  attr_sel = '0;
   logic        attr_bit = 1'b0;
   logic [1:0]  attr_rl = '0;

   logic        ram_req_a, mem_req_a, io_req_a, we_a, fv_a;
   logic [15:0] ram_addr_a;
   logic [22:0] mem_addr_a;
   logic [9:0]  port_a;
   logic [31:0] wd_a;
   logic [3:0]  fc_a;
   logic        ram_req_b, mem_req_b, io_req_b, we_b, fv_b;
   logic [15:0] ram_addr_b;
   logic [22:0] mem_addr_b;
   logic [9:0]  port_b;
   logic [31:0] wd_b;
   logic [3:0]  fc_b;

   seg_addr_router u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
      .seg_base(seg_base), .offset(offset), .cur_rl(cur_rl), .wdata(wdata),
      .attr_we(attr_we), .attr_page(attr_page), .attr_sel(attr_sel),
      .attr_bit(attr_bit), .attr_rl(attr_rl),
      .ram_req(ram_req_a), .ram_addr(ram_addr_a), .mem_req(mem_req_a),
      .mem_addr(mem_addr_a), .io_req(io_req_a), .io_port(port_a),
      .bus_we(we_a), .bus_wdata(wd_a), .fault_vld(fv_a), .fault_code(fc_a));

   seg_addr_router #(.INT_RAM_EN(1'b0)) u_dut_noram (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
      .seg_base(seg_base), .offset(offset), .cur_rl(cur_rl), .wdata(wdata),
      .attr_we(attr_we), .attr_page(attr_page), .attr_sel(attr_sel),
      .attr_bit(attr_bit), .attr_rl(attr_rl),
      .ram_req(ram_req_b), .ram_addr(ram_addr_b), .mem_req(mem_req_b),
      .mem_addr(mem_addr_b), .io_req(io_req_b), .io_port(port_b),
      .bus_we(we_b), .bus_wdata(wd_b), .fault_vld(fv_b), .fault_code(fc_b));

   typedef struct {
      bit ram, mem, io, flt, we;
      int code, raddr, maddr, port;
      longint wd;
   } exp_t;

   int     pr [64], pw [64], px [64], prl [64];
   int     errors = 0, checks = 0;
   bit     pend = 0, done = 0;
   exp_t   exp_a, exp_b;
   string  ptag;

   task automatic chk(string tg, string what, longint act, longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tg, what, act, expv);
      end
   endtask

   function automatic exp_t model(logic [23:0] s, logic [23:0] o, int t, int crl,
                                  bit v, bit has_ram, logic [31:0] wd);
      exp_t e;
      int   a, b, sum, ext, pg;
      e = '{default: 0};
      if (!v) return e;
      a = $signed(s);
      b = $signed(o);
      sum = a + b;
      if (sum > 8388607 || sum < -8388608 || (t == 2 && sum < 0)) begin
         e.flt = 1; e.code = 15;
      end else if (sum < 0) begin
         e.port = -sum - 1;
         if (e.port >= 1024) begin e.flt = 1; e.code = 10; end
         else e.io = 1;
      end else begin
         if (has_ram && sum < 65536) begin
            e.ram = 1; e.raddr = sum;
         end else begin
            ext = has_ram ? sum - 65536 : sum;
            if (ext >= 65536) begin e.flt = 1; e.code = 8; end
            else begin e.mem = 1; e.maddr = ext; end
         end
         if (!e.flt && sum < 64 * 128) begin
            pg = sum / 128;
            if (t == 2 && px[pg] == 0) e.code = 14;
            else if (t == 1 && pw[pg] == 0 && crl > prl[pg]) e.code = 9;
            else if ((t == 0 || t == 3) && pr[pg] == 0 && crl > prl[pg]) e.code = 12;
            if (e.code != 0) begin e.flt = 1; e.ram = 0; e.mem = 0; end
         end
      end
      e.we = (e.ram || e.mem || e.io) && t == 1;
      e.wd = e.we ? longint'(wd) : 0;
      return e;
   endfunction

   task automatic cmp(string tg, string who, exp_t e, bit rr, bit mr, bit ir, bit fv,
                      logic [3:0] fc, logic [15:0] ra, logic [22:0] ma, logic [9:0] pt,
                      bit we, logic [31:0] wd);
      chk(tg, {who, " ram_req"}, rr, e.ram);
      chk(tg, {who, " mem_req"}, mr, e.mem);
      chk(tg, {who, " io_req"}, ir, e.io);
      chk(tg, {who, " fault_vld"}, fv, e.flt);
      chk(tg, {who, " fault_code"}, fc, e.code);
      chk(tg, {who, " bus_we"}, we, e.we);
      chk(tg, {who, " bus_wdata"}, wd, e.wd);
      if (e.ram) chk(tg, {who, " ram_addr"}, ra, e.raddr);
      if (e.mem) chk(tg, {who, " mem_addr"}, ma, e.maddr);
      if (e.io)  chk(tg, {who, " io_port"}, pt, e.port);
   endtask

   task automatic step(logic [23:0] s, logic [23:0] o, int t, int crl, bit v,
                       logic [31:0] wd, bit aw, int apg, int asel, int abit, int arl,
                       string tg);
      @(negedge clk);
      if (pend) begin
         cmp(ptag, "ram", exp_a, ram_req_a, mem_req_a, io_req_a, fv_a, fc_a,
             ram_addr_a, mem_addr_a, port_a, we_a, wd_a);
         cmp(ptag, "noram", exp_b, ram_req_b, mem_req_b, io_req_b, fv_b, fc_b,
             ram_addr_b, mem_addr_b, port_b, we_b, wd_b);
      end
      acc_valid = v; acc_type = 2'(t); seg_base = s; offset = o;
      cur_rl = 2'(crl); wdata = wd;
      attr_we = aw; attr_page = 6'(apg); attr_sel = 2'(asel);
      attr_bit = abit[0]; attr_rl = 2'(arl);
      exp_a = model(s, o, t, crl, v, 1'b1, wd);
      exp_b = model(s, o, t, crl, v, 1'b0, wd);
      if (aw) begin
         case (asel)
            0: pr[apg] = abit;
            1: pw[apg] = abit;
            2: px[apg] = abit;
            default: prl[apg] = arl;
         endcase
      end
      ptag = tg;
      pend = 1;
   endtask

   task automatic acc(logic [23:0] s, logic [23:0] o, int t, int crl,
                      logic [31:0] wd, string tg);
      step(s, o, t, crl, 1'b1, wd, 1'b0, 0, 0, 0, 0, tg);
   endtask

   task automatic attr(int pg, int sel, int b, int rl, string tg);
      step('0, '0, 0, 0, 1'b0, '0, 1'b1, pg, sel, b, rl, tg);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         pr[i] = 1; pw[i] = 1; px[i] = 1; prl[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13", "ram_req", ram_req_a, 0);
      chk("R13", "mem_req", mem_req_a, 0);
      chk("R13", "io_req", io_req_a, 0);
      chk("R13", "fault_vld", fv_a, 0);
      chk("R13", "fault_code", fc_a, 0);
      chk("R13", "bus_wdata", wd_a, 0);
      chk("R13", "noram fault_vld", fv_b, 0);
      rst_n = 1'b1;

      acc(24'd50, 24'd50, 0, 0, 0, "R3");
      acc(24'd0, 24'd65535, 0, 0, 0, "R3");
      acc(24'd65536, 24'd5, 0, 0, 0, "R4");
      acc(24'd65536, 24'd65535, 0, 0, 0, "R4");
      acc(24'd131072, 24'd0, 0, 0, 0, "R4");
      acc(24'd0, 24'hFFFFFF, 0, 0, 0, "R2");
      acc(24'd0, 24'hFFFC00, 0, 0, 0, "R2");
      acc(24'd0, 24'hFFFBFF, 0, 0, 0, "R2");
      acc(24'h7FFFFF, 24'd1, 0, 0, 0, "R1");
      acc(24'h800000, 24'hFFFFFF, 0, 0, 0, "R11");
      acc(24'd0, 24'd0, 0, 0, 0, "R5");
      acc(24'd100, 24'd0, 1, 0, 32'hCAFE_0042, "R12");
      acc(24'd0, 24'hFFFFF0, 1, 0, 32'h1234_5678, "R12");
      acc(24'd0, 24'hFFFFFF, 2, 0, 0, "R9");
      step(24'd0, 24'd0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, "R10");
      acc(24'd0, 24'd200, 0, 3, 0, "R6");

      attr(2, 0, 0, 0, "R6");
      acc(24'd0, 24'd300, 0, 1, 0, "R7");
      acc(24'd0, 24'd300, 0, 0, 0, "R7");
      acc(24'd0, 24'd300, 3, 1, 0, "R12");
      attr(3, 1, 0, 0, "R6");
      acc(24'd0, 24'd400, 1, 2, 32'h0000_BEEF, "R8");
      attr(3, 3, 0, 2, "R6");
      acc(24'd0, 24'd400, 1, 2, 32'h0000_BEEF, "R8");
      acc(24'd0, 24'd400, 1, 3, 32'h0000_BEEF, "R8");
      attr(4, 2, 0, 0, "R6");
      acc(24'd0, 24'd520, 2, 0, 0, "R9");
      acc(24'd0, 24'd520, 0, 3, 0, "R9");
      step(24'd0, 24'd650, 0, 1, 1'b1, 0, 1'b1, 5, 0, 0, 0, "R6");
      acc(24'd0, 24'd650, 0, 1, 0, "R6");
      attr(0, 0, 0, 0, "R6");
      acc(24'd0, 24'd8202, 0, 3, 0, "R6");
      acc(24'd0, 24'd10, 0, 3, 0, "R7");
      acc(24'd0, 24'd10, 0, 3, 0, "R5");

      for (int n = 0; n < 600; n++) begin
         logic [23:0] sb;
         logic [23:0] of;
         int          pick;
         pick = int'($urandom_range(0, 5));
         case (pick)
            0: sb = 24'd0;
            1: sb = 24'd64512;
            2: sb = 24'd130048;
            3: sb = 24'h7FFC00;
            4: sb = 24'h800400;
            default: sb = 24'hFFFC00;
         endcase
         of = 24'($urandom_range(0, 2047));
         if ($urandom_range(0, 1) == 1) of = -of;
         step(sb, of, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              $urandom_range(0, 3) != 0, $urandom, $urandom_range(0, 4) == 0,
              int'($urandom_range(0, 63)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 3)), "R10");
      end
      step(24'd0, 24'd0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, "R10");
      step(24'd0, 24'd0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, "R10");
      done = 1;
      summary();
      $finish;
   end

endmodule